// File: doc/BRIEF.md
# Resumable Realigning Memory Copy Engine

This block copies a region of bytes from any source byte address to any destination byte address over one word-wide memory port. The two addresses may have different offsets within a word, and the length may be any number of bytes. The engine never moves single bytes over the port. It reads whole aligned source words and collects the useful bytes in a small realignment queue. It then writes whole aligned destination words, and the byte enables mark the lanes that belong to the copy. The first and last destination words may be partial.

The state that software can see is three values: the source pointer, the destination pointer and the bytes still to copy. These three values always agree with each other. A copy can be paused, or a memory access can fail. In either case the engine stops and leaves these values on its outputs. Bytes that were read but not yet written count as not copied. A later start with the published values finishes the job, and no byte is repeated or skipped. The copy always runs in ascending address order. The engine makes one memory request at a time and holds it until the memory answers.

Top module: `cpy_engine`

## Requirements
- R1: When a copy completes, every destination byte `dst+i` (for `i` below the length) holds the original source byte `src+i`, and no memory byte outside that destination range has changed. This holds for every pair of source and destination offsets and for any length.
- R2: Every request addresses an aligned word, so address bits [1:0] are zero. A read enables all four lanes. A write enables one contiguous run of lanes, where lane `b` carries bits `8b+7:8b` of the data and address byte `addr+b`. A write never enables more bytes than the published remaining length.
- R3: A copy that runs without interruption issues exactly one write per destination word that the range `[dst, dst+len)` touches.
- R4: A start with a length of zero raises `done` in the next cycle and makes no memory request.
- R5: `busy` is high from the cycle after a non-empty start until the copy stops. `done` is a single-cycle pulse.
- R6: While `pause_req` is high, the engine stops at the next boundary between destination writes and raises `paused`. The published values then satisfy `src_out-src == dst_out-dst == len-len_out`. Destination bytes below `dst_out` are already copied, and bytes from `dst_out` upward are untouched.
- R7: Starting again with the published `src_out`, `dst_out` and `len_out` completes the copy byte-exact.
- R8: A response that carries `mem_fault` stops the engine with `faulted` raised. The failing access is not counted as done. The published state satisfies the same relation as in R6, and a restart from it completes the copy.
- R9: `paused` and `faulted` stay high until the next `start`, and that start clears them.
- R10: While a request waits for `mem_ready`, the request, direction, address, data and enables do not change.
- R11: Write addresses within a copy never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a copy with the values on the three inputs below |
| pause_req | input | 1 | Ask the engine to stop at the next write boundary |
| src_in | input | AW | Source byte address |
| dst_in | input | AW | Destination byte address |
| len_in | input | LW | Byte count |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle pulse when a copy completes |
| paused | output | 1 | Stopped on request; held until the next start |
| faulted | output | 1 | Stopped by a memory fault; held until the next start |
| src_out | output | AW | Published source pointer |
| dst_out | output | AW | Published destination pointer |
| len_out | output | LW | Published remaining byte count |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Aligned word address |
| mem_be | output | DW/8 | Byte lane enables |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |
| mem_fault | input | 1 | Marks the completing request as failed |

## Verification
The bench runs every pairing of the four source offsets with the four destination offsets. It uses lengths that give a partial head word only, a partial tail word only, both, or a single byte. A shift error in the realignment would move bytes into the wrong lanes, and a bad enable would damage a neighbour byte. The bench also pauses and injects faults at random points. Reads that are buffered but not written must then be rolled back. A design that published the fetch pointer instead of the committed pointer would skip bytes on restart, and the range check around `dst_out` would fail. The memory model gives random wait states, so a request that changed while it waited would corrupt a word.

// File: rtl/cpy_pkg.sv
// Shared types for the copy engine.
// Assumes: nothing beyond a 2-bit state encoding.
package cpy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAN  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } cpy_state_e;
endpackage

// File: rtl/cpy_realign_buf.sv
// Byte realignment queue. Appends a run of bytes taken from a read word at
// a given offset, and drops a run of bytes from its head after a write.
// Assumes: push and pop never occur in the same cycle; the caller never
// overfills or overdrains it (checked below).
module cpy_realign_buf #(
    parameter int BYTES = 4,
    parameter int CW    = 4,
    localparam int OW   = $clog2(BYTES),
    localparam int BUFB = 2 * BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push,
    input  logic [8*BYTES-1:0]   push_word,
    input  logic [OW-1:0]        push_off,
    input  logic [CW-1:0]        push_cnt,
    input  logic                 pop,
    input  logic [CW-1:0]        pop_cnt,
    output logic [CW-1:0]        fill,
    output logic [8*BYTES-1:0]   head
);
    logic [8*BUFB-1:0]  q, q_nxt;
    logic [CW-1:0]      fill_q, fill_nxt;
    logic [8*BYTES-1:0] aligned, keep_mask;

    // Select the bytes of the read word that belong to the copy
    always_comb begin
        aligned = push_word >> {push_off, 3'b000};
        for (int i = 0; i < BYTES; i++)
            keep_mask[8*i +: 8] = (CW'(i) < push_cnt) ? 8'hFF : 8'h00;
    end

    // Next queue contents: clear, append behind the tail, or shift out the head
    always_comb begin
        q_nxt    = q;
        fill_nxt = fill_q;
        if (clr) begin
            q_nxt    = '0;
            fill_nxt = '0;
        end else if (push) begin
            q_nxt    = q | ({{(8*BUFB-8*BYTES){1'b0}}, aligned & keep_mask} << {fill_q, 3'b000});
            fill_nxt = fill_q + push_cnt;
        end else if (pop) begin
            q_nxt    = q >> {pop_cnt, 3'b000};
            fill_nxt = fill_q - pop_cnt;
        end
    end

    // Queue registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            fill_q <= '0;
        end else begin
            q      <= q_nxt;
            fill_q <= fill_nxt;
        end
    end

    assign fill = fill_q;
    assign head = q[8*BYTES-1:0];

    // Appending never runs past the queue depth
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (int'(fill_q) + int'(push_cnt) <= BUFB));

    // A write never consumes bytes the queue does not hold
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (pop_cnt <= fill_q));
endmodule

// File: rtl/cpy_lane_pack.sv
// Forms one destination write: byte count, lane-shifted data and enables.
// The count is the smaller of the room left in the destination word and
// the bytes remaining. Assumes: rem is non-zero when the result is used.
module cpy_lane_pack #(
    parameter int BYTES = 4,
    parameter int LW    = 16,
    parameter int CW    = 4,
    localparam int OW   = $clog2(BYTES)
) (
    input  logic [OW-1:0]       d_off,
    input  logic [LW-1:0]       rem,
    input  logic [8*BYTES-1:0]  head,
    output logic [CW-1:0]       n,
    output logic [8*BYTES-1:0]  wdata,
    output logic [BYTES-1:0]    be
);
    logic [CW-1:0]    room;
    logic [BYTES-1:0] low_mask;

    // Size the write and place the bytes in their destination lanes
    always_comb begin
        room  = CW'(BYTES) - CW'(d_off);
        n     = (rem < LW'(room)) ? rem[CW-1:0] : room;
        wdata = head << {d_off, 3'b000};
        for (int i = 0; i < BYTES; i++)
            low_mask[i] = (CW'(i) < n);
        be = low_mask << d_off;
    end
endmodule

// File: rtl/cpy_engine.sv
// Memory-to-memory copy engine with run-time byte realignment.
// Reads aligned source words into a realignment queue. Writes aligned
// destination words with byte enables once the queue holds enough bytes
// for the next destination word. The published pointers and length count
// only written bytes. Queued bytes are dropped on pause or fault, so the
// three published values always agree.
// Assumes: one outstanding request; mem_rdata and mem_fault are valid in
// the cycle mem_ready is high; LW is wider than the byte-count width.
module cpy_engine
    import cpy_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int DW = 32,
    localparam int BYTES = DW / 8,
    localparam int OW    = $clog2(BYTES),
    localparam int CW    = $clog2(2 * BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pause_req,
    input  logic [AW-1:0]    src_in,
    input  logic [AW-1:0]    dst_in,
    input  logic [LW-1:0]    len_in,
    output logic             busy,
    output logic             done,
    output logic             paused,
    output logic             faulted,
    output logic [AW-1:0]    src_out,
    output logic [AW-1:0]    dst_out,
    output logic [LW-1:0]    len_out,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [BYTES-1:0] mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    input  logic             mem_fault
);
    cpy_state_e    state;
    logic [AW-1:0] csrc, cdst;
    logic [LW-1:0] clen;
    logic          at_wb;
    logic          done_q, paused_q, faulted_q;

    logic [CW-1:0] fill, wr_n, rd_k, rd_room;
    logic [DW-1:0] head, wr_data;
    logic [BYTES-1:0] wr_be;
    logic [AW-1:0] fsrc;
    logic [LW-1:0] unfetched;
    logic          buf_clr, buf_push, buf_pop;

    // Fetch side: next source byte to read and how many bytes this read takes
    always_comb begin
        fsrc      = csrc + AW'(fill);
        unfetched = clen - LW'(fill);
        rd_room   = CW'(BYTES) - CW'(fsrc[OW-1:0]);
        rd_k      = (unfetched < LW'(rd_room)) ? unfetched[CW-1:0] : rd_room;
    end

    assign buf_clr  = (state == ST_IDLE) && start;
    assign buf_push = (state == ST_READ)  && mem_ready && !mem_fault;
    assign buf_pop  = (state == ST_WRITE) && mem_ready && !mem_fault;

    cpy_realign_buf #(.BYTES(BYTES), .CW(CW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .push      (buf_push),
        .push_word (mem_rdata),
        .push_off  (fsrc[OW-1:0]),
        .push_cnt  (rd_k),
        .pop       (buf_pop),
        .pop_cnt   (wr_n),
        .fill      (fill),
        .head      (head)
    );

    cpy_lane_pack #(.BYTES(BYTES), .LW(LW), .CW(CW)) u_pack (
        .d_off (cdst[OW-1:0]),
        .rem   (clen),
        .head  (head),
        .n     (wr_n),
        .wdata (wr_data),
        .be    (wr_be)
    );

    // Control sequence and the committed pointer/length state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            csrc      <= '0;
            cdst      <= '0;
            clen      <= '0;
            at_wb     <= 1'b0;
            done_q    <= 1'b0;
            paused_q  <= 1'b0;
            faulted_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        csrc      <= src_in;
                        cdst      <= dst_in;
                        clen      <= len_in;
                        paused_q  <= 1'b0;
                        faulted_q <= 1'b0;
                        at_wb     <= 1'b1;
                        if (len_in == '0) done_q <= 1'b1;
                        else              state  <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (clen == '0) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (pause_req && at_wb) begin
                        paused_q <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (fill >= wr_n) begin
                        state <= ST_WRITE;
                    end else begin
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        at_wb <= 1'b0;
                        if (mem_fault) begin
                            faulted_q <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            state <= ST_PLAN;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (mem_fault) begin
                            faulted_q <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            csrc  <= csrc + AW'(wr_n);
                            cdst  <= cdst + AW'(wr_n);
                            clen  <= clen - LW'(wr_n);
                            at_wb <= 1'b1;
                            state <= ST_PLAN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive: the request comes straight from the state, data from the packer
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = mem_we ? {cdst[AW-1:OW], {OW{1'b0}}} : {fsrc[AW-1:OW], {OW{1'b0}}};
        mem_be    = mem_we ? wr_be : {BYTES{1'b1}};
        mem_wdata = mem_we ? wr_data : '0;
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign paused  = paused_q;
    assign faulted = faulted_q;
    assign src_out = csrc;
    assign dst_out = cdst;
    assign len_out = clen;

    // A write never enables more lanes than bytes remain
    assert_be_within_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != '0) && ($countones(mem_be) <= int'(len_out)));

    // A zero-length start completes at once and never touches memory
    assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len_in == '0) |=> (done && !mem_req));

    // Completion is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Remaining length only shrinks while a copy runs
    assert_len_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (len_out <= $past(len_out)));

    // Source and destination pointers advance together
    assert_ptr_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((src_out - dst_out) == $past(src_out - dst_out)));

    // Completion, pause and fault indications exclude each other
    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, paused, faulted}));

    // A waiting request holds all of its fields
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                     && $stable(mem_be) && $stable(mem_wdata)));
endmodule

// File: tb/cpy_engine_test.sv
// Self-checking bench for cpy_engine: a byte-array memory model with random
// wait states and fault injection, directed offset sweeps and random runs
// with pauses and faults, checked against a reference image.
module cpy_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pause_req = 1'b0;
    logic [AW-1:0] src_in = '0;
    logic [AW-1:0] dst_in = '0;
    logic [LW-1:0] len_in = '0;
    logic          busy, done, paused, faulted;
    logic [AW-1:0] src_out, dst_out;
    logic [LW-1:0] len_out;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          mem_fault = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpy_engine #(.AW(AW), .LW(LW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pause_req(pause_req),
        .src_in(src_in), .dst_in(dst_in), .len_in(len_in),
        .busy(busy), .done(done), .paused(paused), .faulted(faulted),
        .src_out(src_out), .dst_out(dst_out), .len_out(len_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_fault(mem_fault)
    );

    logic [7:0] mem  [256];
    logic [7:0] orig [256];
    logic [7:0] refm [256];

    int n_checks = 0;
    int n_fail   = 0;
    int acc_idx  = 0;
    int fault_at = -1;
    int writes   = 0;
    int bad_align = 0;
    int bad_order = 0;
    int last_waddr = 0;
    int wait_left = 0;

    // Memory model: registered ready after random waits, optional fault
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_fault <= 1'b0;
            wait_left = 0;
        end else if (mem_ready) begin
            if (mem_we && !mem_fault)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[(int'(mem_addr[7:0]) + b) & 255] = mem_wdata[8*b +: 8];
            mem_ready <= 1'b0;
            mem_fault <= 1'b0;
        end else if (mem_req) begin
            if (wait_left == 0) begin
                mem_ready <= 1'b1;
                mem_fault <= (acc_idx == fault_at);
                mem_rdata <= {mem[(int'(mem_addr[7:0]) + 3) & 255], mem[(int'(mem_addr[7:0]) + 2) & 255],
                              mem[(int'(mem_addr[7:0]) + 1) & 255], mem[int'(mem_addr[7:0])]};
                if (mem_addr[1:0] != 2'b00) bad_align++;
                if (!mem_we && mem_be != 4'hF) bad_align++;
                if (mem_we) begin
                    writes++;
                    if (int'(mem_addr[7:0]) < last_waddr) bad_order++;
                    last_waddr = int'(mem_addr[7:0]);
                end
                acc_idx++;
                wait_left = int'($urandom % 3);
            end else begin
                wait_left--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic kick(input int s, input int d, input int l);
        @(negedge clk);
        src_in = AW'(s); dst_in = AW'(d); len_in = LW'(l); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done, paused or faulted; raise pause_req after pause_dly cycles
    task automatic wait_end(input int pause_dly, output bit ok);
        int cyc = 0;
        ok = 1'b1;
        while (!(done || paused || faulted)) begin
            if (cyc == pause_dly) pause_req = 1'b1;
            @(negedge clk);
            cyc++;
            if (cyc > 3000) begin
                ok = 1'b0;
                break;
            end
        end
        pause_req = 1'b0;
    endtask

    task automatic prep(input int s, input int d, input int l);
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'($urandom);
            orig[i] = mem[i];
        end
        for (int i = 0; i < 256; i++) refm[i] = orig[i];
        for (int i = 0; i < l; i++) refm[d + i] = orig[s + i];
        acc_idx = 0; writes = 0; bad_align = 0; bad_order = 0; last_waddr = 0;
    endtask

    // One copy, optionally paused or faulted once, then resumed to the end
    task automatic run(input int s, input int d, input int l,
                       input int pause_dly, input int fault_idx);
        bit ok;
        int mism;
        int consumed;
        int exp_w;
        prep(s, d, l);
        fault_at = fault_idx;
        kick(s, d, l);
        check(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
        wait_end(pause_dly, ok);
        check(ok, "R5", "watchdog first leg", int'(ok), 1);
        fault_at = -1;
        if (paused || faulted) begin
            consumed = l - int'(len_out);
            check((int'(src_out) - s == consumed) && (int'(dst_out) - d == consumed),
                  paused ? "R6" : "R8", "published state consistent",
                  int'(dst_out) - d, consumed);
            mism = 0;
            for (int i = 0; i < l; i++)
                if (mem[d + i] != ((i < consumed) ? refm[d + i] : orig[d + i])) mism++;
            check(mism == 0, paused ? "R6" : "R8", "bytes around dst_out", mism, 0);
            repeat (3) @(negedge clk);
            check(paused || faulted, "R9", "flag held", int'(paused || faulted), 1);
            kick(int'(src_out), int'(dst_out), int'(len_out));
            check(!paused && !faulted, "R9", "flag cleared by start",
                  int'(paused) + int'(faulted), 0);
            if (!done) wait_end(-1, ok);
            check(ok && done, "R7", "resume reaches done", int'(done), 1);
        end else begin
            check(done == 1'b1, "R5", "done seen", int'(done), 1);
            exp_w = ((d + l - 1) >> 2) - (d >> 2) + 1;
            if (fault_idx < 0 && pause_dly < 0)
                check(writes == exp_w, "R3", "write count", writes, exp_w);
        end
        @(negedge clk);
        check(done == 1'b0, "R5", "done is one pulse", int'(done), 0);
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != refm[i]) mism++;
        check(mism == 0, (pause_dly >= 0 || fault_idx >= 0) ? "R7" : "R1",
              "memory image", mism, 0);
        check(bad_align == 0, "R2", "aligned word requests", bad_align, 0);
        check(bad_order == 0, "R11", "ascending writes", bad_order, 0);
    endtask

    initial begin
        int prev;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !paused && !faulted && !mem_req, "R5", "reset state",
              int'(busy) + int'(done) + int'(mem_req), 0);

        // R4: zero length completes in one cycle with no access
        prep(10, 150, 0);
        kick(10, 150, 0);
        check(done == 1'b1, "R4", "zero-length done", int'(done), 1);
        check(acc_idx == 0, "R4", "zero-length accesses", acc_idx, 0);
        @(negedge clk);
        check(done == 1'b0 && !busy, "R4", "zero-length idle", int'(done), 0);

        // R1/R3: all offset pairings with head-only, tail-only, both and single byte
        for (int so = 0; so < 4; so++)
            for (int dof = 0; dof < 4; dof++) begin
                run(16 + so, 140 + dof, 1, -1, -1);
                run(16 + so, 140 + dof, 4, -1, -1);
                run(16 + so, 140 + dof, 11, -1, -1);
            end

        // R6/R7: pause at random points
        for (int t = 0; t < 25; t++)
            run(int'($urandom % 80), 128 + int'($urandom % 80), 1 + int'($urandom % 40),
                int'($urandom % 40), -1);

        // R8: fault on a random access, read or write
        for (int t = 0; t < 25; t++)
            run(int'($urandom % 80), 128 + int'($urandom % 80), 1 + int'($urandom % 40),
                -1, int'($urandom % 12));

        // R1: plain random copies
        for (int t = 0; t < 20; t++)
            run(int'($urandom % 80), 128 + int'($urandom % 80), 1 + int'($urandom % 47), -1, -1);

        // R9/R10: pause while a request waits keeps the flag and the published length
        run(3, 201, 30, 2, -1);
        prev = int'(len_out);
        check(!busy, "R10", "engine idle after resumed copy", int'(busy), 0);
        check(prev == 0, "R7", "length drained", prev, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Global watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog expired: actual 1 expected 0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule